// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 15-bit virtual address into a 12-bit physical address by walking a two-level page table that sits in byte-addressed physical memory. It then fetches the byte at that physical address. A base input names the memory frame that holds the top-level directory. Pages are 32 bytes long, and every table entry is one byte: a valid flag plus a 7-bit frame number.

A client pulses `start_i` with the address to translate. The walker then makes its reads one at a time over a single byte-wide read port. That port uses a request/response handshake with any memory latency. A successful walk takes three reads: the directory entry, then the table entry, then the data byte. A missing mapping at either level ends the walk early and raises a fault. In every case, completion is signalled by a one-cycle `done_o` pulse, and the results stay steady until the next walk begins.

Top module: `ptw_walker`

## Requirements
- R1: The virtual address is split into three 5-bit fields: directory index in bits 14:10, table index in bits 9:5 and byte offset in bits 4:0. The walker reads the directory entry at {base frame, directory index}, then the table entry at {directory-entry frame, table index}, then the data byte at {table-entry frame, byte offset}, strictly in that order.
- R2: Each entry byte has its valid flag in bit 7 and its frame number in bits 6:0.
- R3: After a successful walk, `done_o` pulses with `fault_o` low. `paddr_o` then equals {table-entry frame, byte offset} (frame in bits 11:5), and `data_o` equals the byte read from that address.
- R4: A successful walk issues exactly three memory reads.
- R5: A directory entry with bit 7 clear ends the walk after one read. `done_o` and `fault_o` rise together, and no further read is issued.
- R6: A table entry with bit 7 clear ends the walk after two reads, with `done_o` and `fault_o` raised together.
- R7: `mem_req_o` is a one-cycle pulse, and at most one read is outstanding at a time. The walk waits any number of cycles for `mem_rvalid_i`, which may come one or more cycles after the request.
- R8: `start_i` is accepted only while the walker is idle. A pulse during a walk changes neither the walk's reads nor its results, and does not start another walk.
- R9: `done_o` lasts one cycle. `paddr_o`, `data_o` and `fault_o` hold their values from the done pulse until the next accepted start.
- R10: While reset is asserted and after it is released, the walker is idle, with `done_o`, `fault_o` and `mem_req_o` all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Begin a walk (accepted only when idle) |
| vaddr_i | input | 15 | Virtual address to translate |
| base_frame_i | input | 7 | Frame holding the top-level directory |
| mem_req_o | output | 1 | One-cycle read request |
| mem_addr_o | output | 12 | Read address, valid with `mem_req_o` |
| mem_rvalid_i | input | 1 | Read data returned |
| mem_rdata_i | input | 8 | Returned byte |
| paddr_o | output | 12 | Translated physical address |
| data_o | output | 8 | Byte fetched at `paddr_o` |
| done_o | output | 1 | One-cycle completion pulse |
| fault_o | output | 1 | Walk hit an invalid entry |

## Verification
The bench builds the walker with its default parameters: 5-bit index fields and 7-bit frames. Its memory model therefore spans the whole 4096-byte physical space. This lets tests place the directory in the top frame, 127, and chain through frame 0. It also lets the directory, table and data reads land on the very same byte at either end of memory. The memory model's response latency is varied from zero to several wait cycles, so the hold-off between request and returned byte is exercised at each level.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DIR_REQ,
    ST_DIR_WAIT,
    ST_TBL_REQ,
    ST_TBL_WAIT,
    ST_DAT_REQ,
    ST_DAT_WAIT
  } walk_state_e;

  typedef enum logic [1:0] {
    LVL_DIR,
    LVL_TBL,
    LVL_DAT
  } walk_level_e;

endpackage

// File: rtl/ptw_va_split.sv
module ptw_va_split #(
  parameter int IDX_W   = 5,
  parameter int NFIELDS = 3,
  localparam int VA_W   = NFIELDS * IDX_W
) (
  input  logic [VA_W-1:0]                  va_i,
  output logic [NFIELDS-1:0][IDX_W-1:0]    field_o
);

  // field 0 = byte offset, field 1 = table index, field 2 = directory index
  for (genvar g = 0; g < NFIELDS; g++) begin : g_field
    assign field_o[g] = va_i[g*IDX_W +: IDX_W];
  end

endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        rvalid_i,
  input  logic        entry_ok_i,
  output logic        accept_o,
  output walk_level_e level_o,
  output logic        mem_req_o,
  output logic        cap_frame_o,
  output logic        cap_data_o,
  output logic        set_fault_o,
  output logic        done_o,
  output logic        idle_o
);

  walk_state_e state_q, state_d;
  logic        done_q, done_d;

  always_comb begin
    state_d     = state_q;
    accept_o    = 1'b0;
    mem_req_o   = 1'b0;
    cap_frame_o = 1'b0;
    cap_data_o  = 1'b0;
    set_fault_o = 1'b0;
    level_o     = LVL_DIR;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          accept_o = 1'b1;
          state_d  = ST_DIR_REQ;
        end
      end
      ST_DIR_REQ: begin
        mem_req_o = 1'b1;
        level_o   = LVL_DIR;
        state_d   = ST_DIR_WAIT;
      end
      ST_DIR_WAIT: begin
        level_o = LVL_DIR;
        if (rvalid_i) begin
          if (entry_ok_i) begin
            cap_frame_o = 1'b1;
            state_d     = ST_TBL_REQ;
          end else begin
            set_fault_o = 1'b1;
            state_d     = ST_IDLE;
          end
        end
      end
      ST_TBL_REQ: begin
        mem_req_o = 1'b1;
        level_o   = LVL_TBL;
        state_d   = ST_TBL_WAIT;
      end
      ST_TBL_WAIT: begin
        level_o = LVL_TBL;
        if (rvalid_i) begin
          if (entry_ok_i) begin
            cap_frame_o = 1'b1;
            state_d     = ST_DAT_REQ;
          end else begin
            set_fault_o = 1'b1;
            state_d     = ST_IDLE;
          end
        end
      end
      ST_DAT_REQ: begin
        mem_req_o = 1'b1;
        level_o   = LVL_DAT;
        state_d   = ST_DAT_WAIT;
      end
      ST_DAT_WAIT: begin
        level_o = LVL_DAT;
        if (rvalid_i) begin
          cap_data_o = 1'b1;
          state_d    = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    done_d = set_fault_o | cap_data_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  assign done_o = done_q;
  assign idle_o = (state_q == ST_IDLE);

  // R7
  one_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |=> !mem_req_o);

  // R7
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DIR_WAIT && !rvalid_i) |=> (state_q == ST_DIR_WAIT));

endmodule

// File: rtl/ptw_datapath.sv
module ptw_datapath
  import ptw_pkg::*;
#(
  parameter int IDX_W   = 5,
  parameter int FRAME_W = 7,
  localparam int VA_W   = 3 * IDX_W,
  localparam int PA_W   = FRAME_W + IDX_W,
  localparam int ENT_W  = FRAME_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [VA_W-1:0]    vaddr_i,
  input  logic [FRAME_W-1:0] base_i,
  input  logic               accept_i,
  input  walk_level_e        level_i,
  input  logic               cap_frame_i,
  input  logic               cap_data_i,
  input  logic               set_fault_i,
  input  logic [ENT_W-1:0]   rdata_i,
  output logic [PA_W-1:0]    mem_addr_o,
  output logic [PA_W-1:0]    paddr_o,
  output logic [ENT_W-1:0]   data_o,
  output logic               fault_o
);

  logic [VA_W-1:0]           va_q;
  logic [FRAME_W-1:0]        base_q, frame_q;
  logic [PA_W-1:0]           paddr_q;
  logic [ENT_W-1:0]          data_q;
  logic                      fault_q;
  logic [2:0][IDX_W-1:0]     fld;

  ptw_va_split #(.IDX_W(IDX_W), .NFIELDS(3)) u_split (
    .va_i    (va_q),
    .field_o (fld)
  );

  always_comb begin
    unique case (level_i)
      LVL_DIR: mem_addr_o = {base_q,  fld[2]};
      LVL_TBL: mem_addr_o = {frame_q, fld[1]};
      default: mem_addr_o = {frame_q, fld[0]};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      va_q    <= '0;
      base_q  <= '0;
      frame_q <= '0;
    end else begin
      if (accept_i) begin
        va_q   <= vaddr_i;
        base_q <= base_i;
      end
      if (cap_frame_i) frame_q <= rdata_i[FRAME_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      paddr_q <= '0;
      data_q  <= '0;
      fault_q <= 1'b0;
    end else begin
      if (accept_i)         fault_q <= 1'b0;
      else if (set_fault_i) fault_q <= 1'b1;
      if (cap_data_i) begin
        paddr_q <= {frame_q, fld[0]};
        data_q  <= rdata_i;
      end
    end
  end

  assign paddr_o = paddr_q;
  assign data_o  = data_q;
  assign fault_o = fault_q;

  // R5
  fault_after_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_fault_i && !accept_i) |=> fault_o);

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int IDX_W   = 5,
  parameter int FRAME_W = 7,
  localparam int VA_W   = 3 * IDX_W,
  localparam int PA_W   = FRAME_W + IDX_W,
  localparam int ENT_W  = FRAME_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [VA_W-1:0]    vaddr_i,
  input  logic [FRAME_W-1:0] base_frame_i,
  output logic               mem_req_o,
  output logic [PA_W-1:0]    mem_addr_o,
  input  logic               mem_rvalid_i,
  input  logic [ENT_W-1:0]   mem_rdata_i,
  output logic [PA_W-1:0]    paddr_o,
  output logic [ENT_W-1:0]   data_o,
  output logic               done_o,
  output logic               fault_o
);

  logic        rst_meta_q, rst_sync_n;
  logic        accept, cap_frame, cap_data, set_fault, idle;
  walk_level_e level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  ptw_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .start_i     (start_i),
    .rvalid_i    (mem_rvalid_i),
    .entry_ok_i  (mem_rdata_i[ENT_W-1]),
    .accept_o    (accept),
    .level_o     (level),
    .mem_req_o   (mem_req_o),
    .cap_frame_o (cap_frame),
    .cap_data_o  (cap_data),
    .set_fault_o (set_fault),
    .done_o      (done_o),
    .idle_o      (idle)
  );

  ptw_datapath #(.IDX_W(IDX_W), .FRAME_W(FRAME_W)) u_dp (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .vaddr_i     (vaddr_i),
    .base_i      (base_frame_i),
    .accept_i    (accept),
    .level_i     (level),
    .cap_frame_i (cap_frame),
    .cap_data_i  (cap_data),
    .set_fault_i (set_fault),
    .rdata_i     (mem_rdata_i),
    .mem_addr_o  (mem_addr_o),
    .paddr_o     (paddr_o),
    .data_o      (data_o),
    .fault_o     (fault_o)
  );

  // read counter used only by the checks below
  logic [1:0] rd_cnt_q;
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)                        rd_cnt_q <= '0;
    else if (accept)                        rd_cnt_q <= '0;
    else if (mem_req_o && rd_cnt_q != 2'd3) rd_cnt_q <= rd_cnt_q + 2'd1;
  end

  // R4
  three_reads_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (done_o && !fault_o) |-> (rd_cnt_q == 2'd3));

  // R5
  fault_noreq_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    fault_o |-> !mem_req_o);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done_o |=> !done_o);

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (idle && !start_i) |=> ($stable(paddr_o) && $stable(data_o) && $stable(fault_o)));

endmodule

// File: tb/ptw_walker_test.sv
module ptw_walker_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [14:0] vaddr_i;
  logic [6:0]  base_frame_i;
  logic        mem_req_o;
  logic [11:0] mem_addr_o;
  logic        mem_rvalid_i;
  logic [7:0]  mem_rdata_i;
  logic [11:0] paddr_o;
  logic [7:0]  data_o;
  logic        done_o;
  logic        fault_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int lat    = 0;
  int total_reads = 0;
  int total_dones = 0;
  logic [11:0] rlog [0:63];
  logic [7:0]  mem [0:4095];

  always #2.5 clk = ~clk;

  ptw_walker uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .vaddr_i(vaddr_i),
    .base_frame_i(base_frame_i), .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
    .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i), .paddr_o(paddr_o),
    .data_o(data_o), .done_o(done_o), .fault_o(fault_o)
  );

  // memory model: response 1+lat cycles after the request edge
  logic        pend = 1'b0;
  int          pcnt = 0;
  logic [11:0] paddr_pend = '0;
  always @(posedge clk) begin
    mem_rvalid_i <= 1'b0;
    if (pend) begin
      if (pcnt == 0) begin
        mem_rvalid_i <= 1'b1;
        mem_rdata_i  <= mem[paddr_pend];
        pend         <= 1'b0;
      end else pcnt <= pcnt - 1;
    end
    if (rst_n && mem_req_o) begin
      pend        <= 1'b1;
      pcnt        <= lat;
      paddr_pend  <= mem_addr_o;
      rlog[total_reads % 64] <= mem_addr_o;
      total_reads <= total_reads + 1;
    end
    if (rst_n && done_o) total_dones <= total_dones + 1;
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic pulse_start(input logic [14:0] va, input logic [6:0] base);
    @(negedge clk);
    vaddr_i = va; base_frame_i = base; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // returns 1 when done seen; samples at negedge
  task automatic wait_done(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (done_o) begin seen = 1'b1; break; end
    end
  endtask

  // full walk with bench-side expectation from R1..R6
  task automatic run_walk(input logic [14:0] va, input logic [6:0] base, input int l, input string tag);
    logic [11:0] ea [0:2];
    logic [7:0]  de, te, dat;
    int nexp, r0, d0;
    bit seen, xf;
    lat = l;
    ea[0] = {base, va[14:10]};
    de = mem[ea[0]];
    ea[1] = {de[6:0], va[9:5]};
    te = mem[ea[1]];
    ea[2] = {te[6:0], va[4:0]};
    dat = mem[ea[2]];
    if (!de[7])      begin nexp = 1; xf = 1'b1; end
    else if (!te[7]) begin nexp = 2; xf = 1'b1; end
    else             begin nexp = 3; xf = 1'b0; end
    r0 = total_reads; d0 = total_dones;
    pulse_start(va, base);
    wait_done(seen);
    chk(seen, xf ? (nexp == 1 ? "R5" : "R6") : "R3", {tag, " done"}, seen, 1);
    chk(fault_o == xf, xf ? (nexp == 1 ? "R5" : "R6") : "R3", {tag, " fault"}, fault_o, xf);
    if (!xf) begin
      chk(paddr_o == ea[2], "R3", {tag, " paddr"}, paddr_o, ea[2]);
      chk(data_o == dat, "R3", {tag, " data"}, data_o, dat);
    end
    repeat (lat + 6) @(negedge clk);
    chk(total_reads - r0 == nexp, xf ? (nexp == 1 ? "R5" : "R6") : "R4",
        {tag, " read count"}, total_reads - r0, nexp);
    for (int k = 0; k < nexp && k < total_reads - r0; k++)
      chk(rlog[(r0 + k) % 64] == ea[k], "R1", {tag, " read order"}, rlog[(r0 + k) % 64], ea[k]);
    chk(total_dones - d0 == 1, "R9", {tag, " single done"}, total_dones - d0, 1);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; start_i = 1'b0; vaddr_i = '0; base_frame_i = '0;
    repeat (3) @(negedge clk);
    chk(!done_o && !fault_o && !mem_req_o, "R10", "in reset", {done_o, fault_o, mem_req_o}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!done_o && !fault_o && !mem_req_o, "R10", "after release", {done_o, fault_o, mem_req_o}, 0);
  endtask

  task automatic t_basic();
    mem[{7'd90, 5'd19}]  = 8'h80 | 8'd45;
    mem[{7'd45, 5'd12}]  = 8'h80 | 8'd101;
    mem[{7'd101, 5'd9}]  = 8'h5a;
    run_walk({5'd19, 5'd12, 5'd9}, 7'd90, 0, "basic lat0");
    chk(paddr_o == 12'd3241, "R3", "basic fixed paddr", paddr_o, 3241);
    run_walk({5'd19, 5'd12, 5'd9}, 7'd90, 4, "basic lat4");
  endtask

  task automatic t_latency();
    mem[{7'd12, 5'd1}] = 8'h80 | 8'd77;
    mem[{7'd77, 5'd30}] = 8'h80 | 8'd3;
    mem[{7'd3, 5'd17}] = 8'hc3;
    run_walk({5'd1, 5'd30, 5'd17}, 7'd12, 9, "R7 long wait");
  endtask

  task automatic t_dir_fault();
    mem[{7'd20, 5'd3}] = 8'h33;
    run_walk({5'd3, 5'd7, 5'd2}, 7'd20, 2, "R5 dir invalid");
    repeat (5) @(negedge clk);
    chk(fault_o == 1'b1 && !mem_req_o, "R5", "fault held, no read", fault_o, 1);
  endtask

  task automatic t_tbl_fault();
    mem[{7'd64, 5'd8}] = 8'h80 | 8'd50;
    mem[{7'd50, 5'd21}] = 8'h7f;
    run_walk({5'd8, 5'd21, 5'd0}, 7'd64, 1, "R6 table invalid");
  endtask

  task automatic t_bounds();
    mem[4095] = 8'h80;
    mem[{7'd0, 5'd31}] = 8'hff;
    run_walk(15'h7fff, 7'd127, 0, "R2 frame edges");
    chk(data_o == 8'h80 && paddr_o == 12'hfff, "R2", "top byte self-reference", data_o, 8'h80);
    mem[0] = 8'h80;
    run_walk(15'h0000, 7'd0, 1, "R2 zero chain");
    chk(paddr_o == 12'h000, "R2", "zero paddr", paddr_o, 0);
  endtask

  task automatic t_busy_start();
    int r0, d0;
    bit seen;
    mem[{7'd33, 5'd5}] = 8'h80 | 8'd34;
    mem[{7'd34, 5'd6}] = 8'h80 | 8'd35;
    mem[{7'd35, 5'd7}] = 8'h11;
    mem[{7'd40, 5'd9}] = 8'h80 | 8'd41;
    lat = 5;
    r0 = total_reads; d0 = total_dones;
    pulse_start({5'd5, 5'd6, 5'd7}, 7'd33);
    repeat (3) @(negedge clk);
    pulse_start({5'd9, 5'd9, 5'd9}, 7'd40);
    wait_done(seen);
    chk(paddr_o == {7'd35, 5'd7}, "R8", "busy start paddr", paddr_o, {7'd35, 5'd7});
    chk(data_o == 8'h11, "R8", "busy start data", data_o, 8'h11);
    repeat (30) @(negedge clk);
    chk(total_reads - r0 == 3, "R8", "no second walk reads", total_reads - r0, 3);
    chk(total_dones - d0 == 1, "R8", "no second done", total_dones - d0, 1);
  endtask

  task automatic t_hold();
    logic [11:0] pa;
    logic [7:0]  dv;
    run_walk({5'd19, 5'd12, 5'd9}, 7'd90, 0, "hold setup");
    pa = paddr_o; dv = data_o;
    vaddr_i = 15'h1234; base_frame_i = 7'd5;
    repeat (12) @(negedge clk);
    chk(paddr_o == pa && data_o == dv && !fault_o, "R9", "outputs held", paddr_o, pa);
    chk(!done_o, "R9", "done stays low", done_o, 0);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 8'((i * 29 + 7) ^ (i >> 4));
    t_reset();
    t_basic();
    t_latency();
    t_dir_fault();
    t_tbl_fault();
    t_bounds();
    t_busy_start();
    t_hold();
    summary();
    $finish;
  end

endmodule